// File: doc/BRIEF.md
# Register Write-Readback Self-Test Engine

This block is a built-in self-test controller for a small bank of read/write configuration registers inside a peripheral. It owns a simple register bus (address, write data, write strobe, read strobe, registered read data) and a hard-reset line into that bank. On a start pulse it runs one of two tests and then reports a single outcome.

The pattern test makes 256 passes. In each pass every register under test is written with consecutive 8-bit values that begin at the pass seed, and then every register is read back. Each value read is compared with what was written, but only in the bits the register can actually store (a per-register writable mask). The reset test writes a nonzero fill value to every register, holds the hard-reset line, and then expects each register to read zero in its writable bits. Either test stops at the first mismatch and records an error code with the failing address, the data written and the data read.

The register count, their addresses and their writable masks are parameters. The bus has no back-pressure: the bank must accept a write on any cycle with the write strobe high, and must return read data on the cycle after the read strobe. No valid/ready handshake is used because no data leaves the block as a stream. The results stay on the outputs until the next accepted start.

Top module: `regbist_engine`

## Requirements
- R1: After reset, done, pass and error_valid are 0, and bus_wr, bus_rd and hard_reset are 0 until a start is accepted.
- R2: In pattern mode (mode=0), during pass s (s counting from 0), register i receives the value (s + i) mod 256 at the address in slot i. Registers are visited in slot order from slot 0 upward.
- R3: A pattern run with no mismatch makes 256 passes. That is NUM_REGS*256 writes and as many reads. It ends with done=1, pass=1 and error_valid=0 exactly 3*NUM_REGS*256 cycles after the start is sampled.
- R4: Within a pass, all writes come before any read, and the strobes bus_wr and bus_rd are never high together.
- R5: A readback compares only the bits set in that register's writable mask. A difference in any other bit causes no error.
- R6: The first mismatch ends the run: done=1, pass=0, error_valid=1, and the error record holds the failing address, the data written and the data read. The code is 0x05 in pattern mode. No bus access follows.
- R7: In reset mode (mode=1), the fill value is written to every register, and then hard_reset is held high for RST_CYCLES cycles with no strobe. Each register is then read, and a nonzero value in the writable bits gives error code 0x02 with the fill value as the written data.
- R8: The outputs and the error record hold until the next start. A start that arrives while a run is in progress is ignored, and a start after an error clears the record and runs again.
- R9: Read data is sampled on the cycle after the cycle in which bus_rd is high, and read strobes are never on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle or finished |
| mode | input | 1 | Test select at start: 0 pattern, 1 reset-clear |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_rd |
| hard_reset | output | 1 | Hard reset into the register bank |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no mismatch |
| error_valid | output | 1 | Error record valid |
| error_code | output | 8 | 0x05 pattern mismatch, 0x02 reset not cleared |
| err_addr | output | ADDR_W | Address of the failing register |
| err_wdata | output | DATA_W | Data written to that register |
| err_rdata | output | DATA_W | Data read back from it |

## Verification
The bench places a behavioural register bank behind the bus and injects faults into it. It then tries the pattern test with a clean bank, with a bit stuck outside a writable mask, and with randomly chosen stuck-at bits inside writable masks. The clean bank checks the pattern sequence, the ordering and the run length. The masked stuck bit separates a masked compare from a full compare. The random stuck bits place the first failure at different passes and slots, so the error record, the abort point and the read sampling cycle are all pinned down. The reset test runs with a bank that clears and with one register that ignores reset, which separates a real zero check from one that passes everything.

// File: rtl/regbist_pkg.sv
package regbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_HRST,
    ST_READ,
    ST_CMP,
    ST_DONE
  } rb_state_t;

  localparam logic [7:0] CODE_PATTERN_MISMATCH = 8'h05;
  localparam logic [7:0] CODE_RESET_NOT_CLEAR  = 8'h02;

  localparam logic MODE_PATTERN = 1'b0;
  localparam logic MODE_RESET   = 1'b1;

endpackage

// File: rtl/regbist_pattern_gen.sv
module regbist_pattern_gen #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 2,
  parameter int SEED_W   = 9,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = '0,
  parameter logic [NUM_REGS*DATA_W-1:0] REG_MASKS = '1,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              mode_q,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SEED_W-1:0] seed,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic [DATA_W-1:0] cur_mask
);
  import regbist_pkg::*;

  logic [ADDR_W-1:0] addr_tab [NUM_REGS];
  logic [DATA_W-1:0] mask_tab [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign addr_tab[g] = REG_ADDRS[g*ADDR_W +: ADDR_W];
    assign mask_tab[g] = REG_MASKS[g*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] rolling;
  assign rolling = DATA_W'(seed) + DATA_W'(idx);

  assign cur_addr  = addr_tab[idx];
  assign cur_mask  = mask_tab[idx];
  assign cur_wdata = (mode_q == MODE_RESET) ? FILL : rolling;
endmodule

// File: rtl/regbist_compare.sv
module regbist_compare #(
  parameter int DATA_W = 8
) (
  input  logic              mode_q,
  input  logic [DATA_W-1:0] written,
  input  logic [DATA_W-1:0] readback,
  input  logic [DATA_W-1:0] mask,
  output logic              mismatch
);
  import regbist_pkg::*;

  logic [DATA_W-1:0] expected;
  assign expected = (mode_q == MODE_RESET) ? '0 : written;
  assign mismatch = |((readback ^ expected) & mask);
endmodule

// File: rtl/regbist_ctrl.sv
module regbist_ctrl #(
  parameter int NUM_REGS   = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int NUM_PASSES = 256,
  parameter int RST_CYCLES = 2,
  parameter int IDX_W      = 2,
  parameter int SEED_W     = 9,
  parameter int HC_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_in,
  input  logic              mismatch,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic              mode_q,
  output logic [IDX_W-1:0]  idx,
  output logic [SEED_W-1:0] seed,
  output logic              wr,
  output logic              rd,
  output logic              hrst,
  output logic              done,
  output logic              pass,
  output logic              error_valid,
  output logic [7:0]        error_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_wdata,
  output logic [DATA_W-1:0] err_rdata
);
  import regbist_pkg::*;

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_REGS - 1);
  localparam logic [SEED_W-1:0] LAST_SEED = SEED_W'(NUM_PASSES - 1);
  localparam logic [HC_W-1:0]   LAST_HC   = HC_W'(RST_CYCLES - 1);

  rb_state_t       state;
  logic [HC_W-1:0] hcnt;

  assign wr   = (state == ST_WRITE);
  assign rd   = (state == ST_READ);
  assign hrst = (state == ST_HRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode_q      <= MODE_PATTERN;
      idx         <= '0;
      seed        <= '0;
      hcnt        <= '0;
      done        <= 1'b0;
      pass        <= 1'b0;
      error_valid <= 1'b0;
      error_code  <= '0;
      err_addr    <= '0;
      err_wdata   <= '0;
      err_rdata   <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state       <= ST_WRITE;
            mode_q      <= mode_in;
            idx         <= '0;
            seed        <= '0;
            hcnt        <= '0;
            done        <= 1'b0;
            pass        <= 1'b0;
            error_valid <= 1'b0;
            error_code  <= '0;
            err_addr    <= '0;
            err_wdata   <= '0;
            err_rdata   <= '0;
          end
        end
        ST_WRITE: begin
          if (idx == LAST_IDX) begin
            idx   <= '0;
            hcnt  <= '0;
            state <= (mode_q == MODE_RESET) ? ST_HRST : ST_READ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_HRST: begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == LAST_HC) state <= ST_READ;
        end
        ST_READ: begin
          state <= ST_CMP;
        end
        ST_CMP: begin
          if (mismatch) begin
            state       <= ST_DONE;
            done        <= 1'b1;
            error_valid <= 1'b1;
            error_code  <= (mode_q == MODE_RESET) ? CODE_RESET_NOT_CLEAR
                                                  : CODE_PATTERN_MISMATCH;
            err_addr    <= cur_addr;
            err_wdata   <= cur_wdata;
            err_rdata   <= rdata;
          end else if (idx == LAST_IDX) begin
            idx <= '0;
            if (mode_q == MODE_RESET || seed == LAST_SEED) begin
              state <= ST_DONE;
              done  <= 1'b1;
              pass  <= 1'b1;
            end else begin
              seed  <= seed + 1'b1;
              state <= ST_WRITE;
            end
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regbist_engine.sv
module regbist_engine #(
  parameter int NUM_REGS   = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int NUM_PASSES = 256,
  parameter int RST_CYCLES = 2,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = 32'h0C0B0A09,
  parameter logic [NUM_REGS*DATA_W-1:0] REG_MASKS = 32'hFF3FFFF0,
  parameter logic [DATA_W-1:0] FILL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              hard_reset,
  output logic              done,
  output logic              pass,
  output logic              error_valid,
  output logic [7:0]        error_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_wdata,
  output logic [DATA_W-1:0] err_rdata
);
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int SEED_W = $clog2(NUM_PASSES + 1);
  localparam int HC_W   = $clog2(RST_CYCLES + 1);

  logic              mode_q;
  logic [IDX_W-1:0]  idx;
  logic [SEED_W-1:0] seed;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] cur_mask;
  logic              mismatch;

  regbist_pattern_gen #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .SEED_W   (SEED_W),
    .REG_ADDRS(REG_ADDRS),
    .REG_MASKS(REG_MASKS),
    .FILL     (FILL)
  ) pgen_i (
    .mode_q   (mode_q),
    .idx      (idx),
    .seed     (seed),
    .cur_addr (cur_addr),
    .cur_wdata(cur_wdata),
    .cur_mask (cur_mask)
  );

  regbist_compare #(
    .DATA_W(DATA_W)
  ) cmp_i (
    .mode_q  (mode_q),
    .written (cur_wdata),
    .readback(bus_rdata),
    .mask    (cur_mask),
    .mismatch(mismatch)
  );

  regbist_ctrl #(
    .NUM_REGS  (NUM_REGS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_PASSES(NUM_PASSES),
    .RST_CYCLES(RST_CYCLES),
    .IDX_W     (IDX_W),
    .SEED_W    (SEED_W),
    .HC_W      (HC_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_in    (mode),
    .mismatch   (mismatch),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .rdata      (bus_rdata),
    .mode_q     (mode_q),
    .idx        (idx),
    .seed       (seed),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .hrst       (hard_reset),
    .done       (done),
    .pass       (pass),
    .error_valid(error_valid),
    .error_code (error_code),
    .err_addr   (err_addr),
    .err_wdata  (err_wdata),
    .err_rdata  (err_rdata)
  );

  assign bus_addr  = cur_addr;
  assign bus_wdata = cur_wdata;
endmodule

// File: rtl/regbist_engine_chk.sv
module regbist_engine_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              hard_reset,
  input logic              done,
  input logic              pass,
  input logic              error_valid,
  input logic [7:0]        error_code,
  input logic [ADDR_W-1:0] err_addr,
  input logic [DATA_W-1:0] err_wdata,
  input logic [DATA_W-1:0] err_rdata
);
  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R7
  hrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_reset |-> (!bus_wr && !bus_rd));

  // R9
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);

  // R6
  err_means_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_valid |-> (done && !pass));

  // R6
  bus_idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_wr && !bus_rd && !hard_reset));

  // R3
  pass_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> !error_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(error_code) &&
                          $stable(err_addr) && $stable(err_wdata) && $stable(err_rdata)));
endmodule

bind regbist_engine regbist_engine_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .hard_reset (hard_reset),
  .done       (done),
  .pass       (pass),
  .error_valid(error_valid),
  .error_code (error_code),
  .err_addr   (err_addr),
  .err_wdata  (err_wdata),
  .err_rdata  (err_rdata)
);

// File: tb/regbist_engine_tb.sv
module regbist_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG   = 4;
  localparam int PASSES = 256;
  localparam int RSTC   = 2;
  localparam logic [31:0] TB_ADDRS = 32'h0C0B0A09;
  localparam logic [31:0] TB_MASKS = 32'hFF3FFFF0;
  localparam logic [7:0]  TB_FILL  = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_wr, bus_rd, hard_reset, done, pass, error_valid;
  logic [7:0] error_code, err_addr, err_wdata, err_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbist_engine #(
    .NUM_REGS(NREG), .ADDR_W(8), .DATA_W(8), .NUM_PASSES(PASSES),
    .RST_CYCLES(RSTC), .REG_ADDRS(TB_ADDRS), .REG_MASKS(TB_MASKS), .FILL(TB_FILL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .hard_reset(hard_reset), .done(done), .pass(pass),
    .error_valid(error_valid), .error_code(error_code), .err_addr(err_addr),
    .err_wdata(err_wdata), .err_rdata(err_rdata)
  );

  function automatic logic [7:0] addr_of(input int i);
    return TB_ADDRS[i*8 +: 8];
  endfunction
  function automatic logic [7:0] mask_of(input int i);
    return TB_MASKS[i*8 +: 8];
  endfunction

  // fault controls of the register bank model
  int stuck_reg = -1;
  int stuck_bit = 0;
  int stuck_val = 0;
  int noclr_reg = -1;

  function automatic logic [7:0] apply_fault(input logic [7:0] v, input int i);
    logic [7:0] r;
    r = v;
    if (i == stuck_reg) begin
      r[stuck_bit] = stuck_val[0];
    end
    return r;
  endfunction

  logic [7:0] mregs [NREG];
  initial begin
    for (int i = 0; i < NREG; i++) mregs[i] = 8'h00;
    bus_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (hard_reset) begin
      for (int i = 0; i < NREG; i++) if (i != noclr_reg) mregs[i] <= 8'h00;
    end else if (bus_wr) begin
      for (int i = 0; i < NREG; i++)
        if (bus_addr == addr_of(i)) mregs[i] <= bus_wdata & mask_of(i);
    end
    if (bus_rd) begin
      for (int i = 0; i < NREG; i++)
        if (bus_addr == addr_of(i)) bus_rdata <= apply_fault(mregs[i], i);
    end
  end

  // bus monitor: sequence, ordering and totals
  int tot_wr = 0, tot_rd = 0, tot_hr = 0;
  int val_err = 0, ord_err = 0;
  int mw = 0, wr_in_pass = 0, rd_in_pass = 0;
  bit mon_mode = 1'b0;
  bit seen_start = 1'b0;

  always @(posedge clk) begin
    if (rst_n && start && (done || !seen_start)) begin
      seen_start = 1'b1;
      mon_mode = mode;
      mw = 0; wr_in_pass = 0; rd_in_pass = 0;
    end else if (rst_n) begin
      if (hard_reset) tot_hr++;
      if (bus_wr) begin
        tot_wr++;
        if (bus_addr != addr_of(mw % NREG)) val_err++;
        if (!mon_mode && bus_wdata != 8'(((mw / NREG) + (mw % NREG)) & 255)) val_err++;
        if (mon_mode && bus_wdata != TB_FILL) val_err++;
        if (rd_in_pass != 0 && rd_in_pass != NREG) ord_err++;
        if (rd_in_pass == NREG) rd_in_pass = 0;
        wr_in_pass++;
        mw++;
      end
      if (bus_rd) begin
        tot_rd++;
        if (wr_in_pass != NREG) ord_err++;
        rd_in_pass++;
        if (rd_in_pass == NREG) wr_in_pass = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_test(input bit m, input int poke_cyc, output int cyc);
    @(negedge clk);
    start = 1'b1;
    mode = m;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_cyc) begin
        start = 1'b1;
        mode = ~m;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  // expected first failure for a stuck bit: returns failing seed, -1 if none
  function automatic int first_fail_seed(input int k, input int b, input int v);
    for (int s = 0; s < PASSES; s++) begin
      for (int i = 0; i < NREG; i++) begin
        logic [7:0] w, st, rb;
        w = 8'((s + i) & 255);
        st = w & mask_of(i);
        rb = st;
        if (i == k) rb[b] = v[0];
        if (((rb ^ w) & mask_of(i)) != 8'h00) return s;
      end
    end
    return -1;
  endfunction

  task automatic check_clean_pattern(input string tag, input int poke);
    int cyc, w0, r0, ve0, oe0;
    w0 = tot_wr; r0 = tot_rd; ve0 = val_err; oe0 = ord_err;
    run_test(1'b0, poke, cyc);
    chk(cyc == 3*NREG*PASSES, {tag, " R3 run length"}, cyc, 3*NREG*PASSES);
    chk(done && pass && !error_valid, {tag, " R3 pass flags"}, {done, pass, error_valid}, 3'b110);
    chk(tot_wr - w0 == NREG*PASSES, {tag, " R3 write count"}, tot_wr - w0, NREG*PASSES);
    chk(tot_rd - r0 == NREG*PASSES, {tag, " R3 read count"}, tot_rd - r0, NREG*PASSES);
    chk(val_err == ve0, {tag, " R2 write sequence"}, val_err - ve0, 0);
    chk(ord_err == oe0, {tag, " R4 write-then-read order"}, ord_err - oe0, 0);
  endtask

  initial begin
    int cyc, w0, r0, h0, s_exp, k, b, v;
    logic [7:0] wexp, rexp;
    void'($urandom(32'd20240517));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!done && !pass && !error_valid, "R1 status in reset", {done, pass, error_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bus_wr && !bus_rd && !hard_reset, "R1 bus idle", {bus_wr, bus_rd, hard_reset}, 0);
    chk(!done && !pass && !error_valid, "R1 status after reset", {done, pass, error_valid}, 0);

    // R8: clean run with a start poked in mid-run (must be ignored)
    check_clean_pattern("clean+poke R8", 100);
    w0 = tot_wr; r0 = tot_rd;
    repeat (10) @(negedge clk);
    chk(done && pass && tot_wr == w0 && tot_rd == r0, "R8 result held", {done, pass}, 2'b11);

    // R5: stuck bit outside a writable mask causes no error
    stuck_reg = 0; stuck_bit = 0; stuck_val = 1;
    check_clean_pattern("masked stuck R5", 0);

    // R6/R9: random stuck bits inside writable masks
    for (int t = 0; t < 6; t++) begin
      k = int'($urandom % NREG);
      do b = int'($urandom % 8); while (!mask_of(k)[b]);
      v = int'($urandom % 2);
      if (t == 0) begin k = 3; b = 7; v = 1; end   // fails in pass 0
      if (t == 1) begin k = 0; b = 7; v = 1; end   // fails at seed 0 on bit 7 set
      stuck_reg = k; stuck_bit = b; stuck_val = v;
      s_exp = first_fail_seed(k, b, v);
      wexp = 8'((s_exp + k) & 255);
      rexp = wexp & mask_of(k);
      rexp[b] = v[0];
      run_test(1'b0, 0, cyc);
      chk(done && !pass && error_valid, "R6 fail flags", {done, pass, error_valid}, 3'b101);
      chk(error_code == 8'h05, "R6 error code", error_code, 8'h05);
      chk(err_addr == addr_of(k), "R6 error address", err_addr, addr_of(k));
      chk(err_wdata == wexp, "R6 written data", err_wdata, wexp);
      chk(err_rdata == rexp, "R9 read data sample", err_rdata, rexp);
      chk(cyc == s_exp*3*NREG + NREG + 2*(k+1), "R6 abort point", cyc, s_exp*3*NREG + NREG + 2*(k+1));
      w0 = tot_wr; r0 = tot_rd;
      repeat (8) @(negedge clk);
      chk(tot_wr == w0 && tot_rd == r0, "R6 no access after abort", tot_wr - w0 + tot_rd - r0, 0);
    end
    stuck_reg = -1;

    // R7: reset mode, clean bank
    h0 = tot_hr; w0 = tot_wr;
    run_test(1'b1, 0, cyc);
    chk(cyc == 3*NREG + RSTC, "R7 reset run length", cyc, 3*NREG + RSTC);
    chk(done && pass && !error_valid, "R7 reset pass", {done, pass, error_valid}, 3'b110);
    chk(tot_hr - h0 == RSTC, "R7 hard reset width", tot_hr - h0, RSTC);
    chk(tot_wr - w0 == NREG, "R7 fill writes", tot_wr - w0, NREG);

    // R7: one register ignores reset
    noclr_reg = 2;
    run_test(1'b1, 0, cyc);
    chk(error_valid && !pass && error_code == 8'h02, "R7 reset error code", error_code, 8'h02);
    chk(err_addr == addr_of(2), "R7 error address", err_addr, addr_of(2));
    chk(err_wdata == TB_FILL, "R7 written data", err_wdata, TB_FILL);
    chk(err_rdata == (TB_FILL & mask_of(2)), "R7 read data", err_rdata, TB_FILL & mask_of(2));
    chk(cyc == NREG + RSTC + 2*3, "R7 abort point", cyc, NREG + RSTC + 6);
    noclr_reg = -1;

    // R8: restart after an error clears the record
    check_clean_pattern("restart R8", 0);
    chk(error_code == 8'h00 && err_addr == 8'h00, "R8 record cleared", {error_code, err_addr}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule